// File: doc/BRIEF.md
# Dual-Scheme SPI Serial Clock Divider

This block derives the serial clock of a SPI controller from its module clock. It also produces two single-cycle strobes that tell the serial shift engine when the clock has just left its idle level (the leading edge) and when it has just returned to it (the trailing edge). Two division schemes are available and one input picks between them. The linear scheme divides by 2 × (L + 1), where L is an unsigned field that is 8 bits wide by default. The exponential scheme divides by 2^(E + 1), where E is a field that is 4 bits wide by default. Either way, each half of the serial clock period lasts the same number of module clocks, so the duty cycle is 50%.

A surrounding controller raises the run input for the length of a transfer. While run is low, the counter is held cleared and the clock rests at the requested idle level. The divider fields may be rewritten at any time. A new value is picked up only at a half-period boundary, so a half period that has already started always finishes with the length it started with. With a 24 MHz module clock, the fastest setting (linear, L = 0) gives 12 MHz, and the linear scheme reaches divisors from 2 to 512.

Top module: `spi_sclk_divgen`

## Requirements
- R1: With the scheme input at 1 (linear), each half period of `sclk_o` lasts `lin_div_i` + 1 module clocks.
- R2: With the scheme input at 0 (exponential), each half period of `sclk_o` lasts 2^`exp_div_i` module clocks.
- R3: The linear extremes hold: `lin_div_i` = 0 gives a toggle every module clock (divide by 2), and `lin_div_i` = 255 gives 256-clock halves (divide by 512).
- R4: A change to `mode_lin_i`, `lin_div_i` or `exp_div_i` does not shorten or stretch the half period in progress. The new length applies from the half period that begins at the next toggle.
- R5: On every clock edge at which `run_i` is 0, the counter clears, `sclk_o` takes the value of `idle_lvl_i`, and no strobe is issued. The idle level is sampled only while stopped, so a change of `idle_lvl_i` during a run has no effect on the running clock.
- R6: `lead_o` is high for exactly the one module clock in which `sclk_o` has just moved from the idle level to the active level.
- R7: `trail_o` is high for exactly the one module clock in which `sclk_o` has just moved back from the active level to the idle level. `lead_o` and `trail_o` are never high together.
- R8: While `rst_ni` is low, `sclk_o`, `lead_o` and `trail_o` are all 0.
- R9: After `run_i` rises, the first toggle of `sclk_o` (a leading edge) appears after one full half period, counted from the first clock edge at which `run_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High while the serial clock should run |
| idle_lvl_i | input | 1 | Level of `sclk_o` while stopped |
| mode_lin_i | input | 1 | Division scheme: 1 = linear, 0 = exponential |
| lin_div_i | input | LIN_W | Linear divider field L |
| exp_div_i | input | EXP_W | Exponential divider field E |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle pulse on each leading edge |
| trail_o | output | 1 | One-cycle pulse on each trailing edge |

## Verification
The bench builds the block with an 8-bit linear field, so it can run the full linear range, including the divide-by-512 extreme. It narrows the exponential field to 3 bits, which caps the exponential half period at 128 clocks. That keeps every exponent, up to the top of its field, affordable within the run. The mid-phase field rewrite, the stop in the middle of a half period, and the inverted idle level are all set up with these values, and a behavioural model is compared against the block on every clock.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

    // Division scheme; the encoding matches the mode_lin_i pin.
    typedef enum logic {
        DIV_EXP = 1'b0,
        DIV_LIN = 1'b1
    } div_mode_e;

    // Registered state of the edge generator.
    typedef struct packed {
        logic sclk;
        logic idle;
        logic lead;
        logic trail;
    } edge_state_t;

endpackage

// File: rtl/spi_div_ratio.sv
module spi_div_ratio
    import spi_div_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             mode_lin_i,
    input  logic [LIN_W-1:0] lin_div_i,
    input  logic [EXP_W-1:0] exp_div_i,
    output logic [CNT_W-1:0] half_len_o
);
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] lin_len;
    logic [CNT_W-1:0] exp_len;
    div_mode_e        mode;

    assign mode    = div_mode_e'(mode_lin_i);
    assign lin_len = {{(CNT_W-LIN_W){1'b0}}, lin_div_i} + ONE;

    // Power-of-two half length: one-hot decode of the exponent field.
    for (genvar g = 0; g <= EXP_MAX; g++) begin : g_exp_bit
        assign exp_len[g] = (exp_div_i == EXP_W'(g));
    end
    if (CNT_W > EXP_MAX + 1) begin : g_exp_pad
        assign exp_len[CNT_W-1:EXP_MAX+1] = '0;
    end

    always_comb begin
        unique case (mode)
            DIV_LIN: half_len_o = lin_len;
            default: half_len_o = exp_len;
        endcase
    end

endmodule

// File: rtl/spi_div_timer.sv
module spi_div_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CNT_W-1:0] half_len_i,
    output logic             wrap_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] half_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
    } timer_state_t;

    timer_state_t st_d, st_q;
    logic         at_end;

    assign at_end = (st_q.cnt == (st_q.half - ONE));
    assign wrap_o = run_i && at_end;
    assign cnt_o  = st_q.cnt;
    assign half_o = st_q.half;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt  = '0;
            st_d.half = half_len_i;
        end else if (at_end) begin
            // Half-period boundary: the only point where a new length is taken.
            st_d.cnt  = '0;
            st_d.half = half_len_i;
        end else begin
            st_d.cnt  = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt  <= '0;
            st_q.half <= ONE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_div_edge.sv
module spi_div_edge
    import spi_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic idle_lvl_i,
    input  logic wrap_i,
    output logic sclk_o,
    output logic idle_o,
    output logic lead_o,
    output logic trail_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        if (!run_i) begin
            st_d.sclk = idle_lvl_i;
            st_d.idle = idle_lvl_i;
        end else if (wrap_i) begin
            st_d.sclk  = ~st_q.sclk;
            st_d.lead  = (st_q.sclk == st_q.idle);
            st_d.trail = (st_q.sclk != st_q.idle);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o  = st_q.sclk;
    assign idle_o  = st_q.idle;
    assign lead_o  = st_q.lead;
    assign trail_o = st_q.trail;

endmodule

// File: rtl/spi_sclk_divgen.sv
module spi_sclk_divgen #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             idle_lvl_i,
    input  logic             mode_lin_i,
    input  logic [LIN_W-1:0] lin_div_i,
    input  logic [EXP_W-1:0] exp_div_i,
    output logic             sclk_o,
    output logic             lead_o,
    output logic             trail_o
);
    localparam int EXP_TOP = (1 << EXP_W);
    localparam int CNT_W   = (LIN_W + 1 > EXP_TOP) ? LIN_W + 1 : EXP_TOP;

    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] tmr_cnt;
    logic [CNT_W-1:0] tmr_half;
    logic             wrap;
    logic             idle_q;

    spi_div_ratio #(
        .LIN_W (LIN_W),
        .EXP_W (EXP_W),
        .CNT_W (CNT_W)
    ) u_ratio (
        .mode_lin_i (mode_lin_i),
        .lin_div_i  (lin_div_i),
        .exp_div_i  (exp_div_i),
        .half_len_o (half_len)
    );

    spi_div_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_i),
        .half_len_i (half_len),
        .wrap_o     (wrap),
        .cnt_o      (tmr_cnt),
        .half_o     (tmr_half)
    );

    spi_div_edge u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_i),
        .idle_lvl_i (idle_lvl_i),
        .wrap_i     (wrap),
        .sclk_o     (sclk_o),
        .idle_o     (idle_q),
        .lead_o     (lead_o),
        .trail_o    (trail_o)
    );

endmodule

// File: rtl/spi_div_checker.sv
module spi_div_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_i,
    input logic             idle_lvl_i,
    input logic             sclk_i,
    input logic             lead_i,
    input logic             trail_i,
    input logic             idle_q_i,
    input logic             wrap_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] half_i
);
    // R1 R2: the phase counter never passes the latched half length.
    a_r1_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i < half_i);

    // R4: the latched half length only moves while stopped or at a boundary.
    a_r4_len_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(run_i) && !$past(wrap_i)) |-> $stable(half_i));

    // R5: a stopped cycle parks the clock at the idle level with no strobes.
    a_r5_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (sclk_i == $past(idle_lvl_i)) && !lead_i && !trail_i);

    // R6: a lead strobe coincides with a fresh move to the active level.
    a_r6_lead_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lead_i |-> (sclk_i != idle_q_i) && (sclk_i != $past(sclk_i)));

    // R7: a trail strobe coincides with a fresh return to idle.
    a_r7_trail_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trail_i |-> (sclk_i == idle_q_i) && (sclk_i != $past(sclk_i)));

    // R7: the two strobes are exclusive.
    a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({lead_i, trail_i}) <= 1);

endmodule

bind spi_sclk_divgen spi_div_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .idle_lvl_i (idle_lvl_i),
    .sclk_i     (sclk_o),
    .lead_i     (lead_o),
    .trail_i    (trail_o),
    .idle_q_i   (idle_q),
    .wrap_i     (wrap),
    .cnt_i      (tmr_cnt),
    .half_i     (tmr_half)
);

// File: tb/tb_spi_sclk_divgen.sv
module tb_spi_sclk_divgen;
    localparam int LIN_W = 8;
    localparam int EXP_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic             idle_lvl = 1'b0;
    logic             mode_lin = 1'b1;
    logic [LIN_W-1:0] lin_div = '0;
    logic [EXP_W-1:0] exp_div = '0;
    logic             sclk, lead, trail;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_cnt = 0, m_half = 1;
    bit m_sclk = 0, m_idle = 0, m_lead = 0, m_trail = 0;

    always #5 clk = ~clk;

    spi_sclk_divgen #(.LIN_W(LIN_W), .EXP_W(EXP_W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .idle_lvl_i(idle_lvl),
        .mode_lin_i(mode_lin), .lin_div_i(lin_div), .exp_div_i(exp_div),
        .sclk_o(sclk), .lead_o(lead), .trail_o(trail));

    function automatic int req_half();
        if (mode_lin) return int'(lin_div) + 1;
        return 1 << int'(exp_div);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: every posedge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_half = 1; m_sclk = 0; m_idle = 0; m_lead = 0; m_trail = 0;
        end else if (!run) begin
            m_cnt = 0; m_half = req_half(); m_sclk = idle_lvl; m_idle = idle_lvl;
            m_lead = 0; m_trail = 0;
        end else if (m_cnt == m_half - 1) begin
            m_lead = (m_sclk == m_idle);
            m_trail = !m_lead;
            m_sclk = !m_sclk;
            m_cnt = 0;
            m_half = req_half();
        end else begin
            m_cnt++;
            m_lead = 0; m_trail = 0;
        end
    end

    // Cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check(sclk == m_sclk, !run ? "R5 sclk" : (mode_lin ? "R1 sclk" : "R2 sclk"), sclk, m_sclk);
            check(lead == m_lead, "R6 lead", lead, m_lead);
            check(trail == m_trail, "R7 trail", trail, m_trail);
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_strobe(input bit want_lead);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (want_lead ? lead : trail) return;
        end
    endtask

    // Counts negedges from a seen lead until trail shows.
    task automatic measure(input int exp_half, input string tag);
        int n = 0;
        wait_strobe(1'b1);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            n++;
            if (trail) break;
        end
        check(n == exp_half, tag, n, exp_half);
    endtask

    task automatic restart();
        @(negedge clk); run = 1'b0;
        @(negedge clk); run = 1'b1;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R8: outputs low in reset
        check(sclk == 0 && lead == 0 && trail == 0, "R8 reset", {sclk, lead, trail}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: fastest linear setting
        mode_lin = 1'b1; lin_div = 8'd0; restart();
        measure(1, "R3 lin min");
        // R1: mid linear
        lin_div = 8'd4; restart();
        measure(5, "R1 lin 4");
        lin_div = 8'd12; restart();
        measure(13, "R1 lin 12");
        // R3: slowest linear setting
        lin_div = 8'd255; restart();
        measure(256, "R3 lin max");

        // R2: exponential scheme across the field
        mode_lin = 1'b0;
        for (int e = 0; e < 8; e++) begin
            exp_div = EXP_W'(e); restart();
            measure(1 << e, "R2 exp");
        end

        // R9: first leading edge comes one half period after run rises
        mode_lin = 1'b1; lin_div = 8'd6;
        @(negedge clk); run = 1'b0;
        @(negedge clk); run = 1'b1;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); n++;
            if (lead) break;
        end
        check(n == 7, "R9 first edge", n, 7);

        // R4: rewrite mid-phase keeps current half, then applies
        lin_div = 8'd9; restart();
        wait_strobe(1'b1);
        repeat (2) @(negedge clk);
        lin_div = 8'd2;
        n = 2;
        for (int i = 0; i < 100; i++) begin
            if (trail) break;
            @(negedge clk); n++;
        end
        check(n == 10, "R4 old length kept", n, 10);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); n++;
            if (lead) break;
        end
        check(n == 3, "R4 new length applied", n, 3);
        // R4: scheme switch also deferred
        mode_lin = 1'b0; exp_div = 3'd2;
        measure(4, "R4 scheme switch");

        // R5: stop mid-phase with idle high, hold, no strobes
        mode_lin = 1'b1; lin_div = 8'd7;
        repeat (3) @(negedge clk);
        idle_lvl = 1'b1; run = 1'b0;
        @(negedge clk);
        check(sclk == 1, "R5 park high", sclk, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(sclk == 1 && !lead && !trail, "R5 held", {sclk, lead, trail}, 3'b100);
        end
        // R6: with idle high, lead marks the drop to 0
        run = 1'b1;
        wait_strobe(1'b1);
        check(sclk == 0, "R6 lead active low", sclk, 0);
        // R5: idle change during run has no effect
        idle_lvl = 1'b0;
        wait_strobe(1'b0);
        check(sclk == 1, "R5 idle ignored while running", sclk, 1);
        measure(8, "R5 R7 period after idle change");

        run = 1'b0;
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule